// File: doc/BRIEF.md
# Ethernet Transmit Collision Supervisor

This block sits beside a 10/100 half-duplex Ethernet MAC transmitter and supervises what happens around collisions for every frame. It follows a frame from its start strobe, counts transmitted bytes, and sorts each collision as early or late. After an early collision it runs a truncated binary exponential backoff and then hands the attempt back for retransmission. When the retry budget is used up, or when a collision is late, it ends the frame. After a clean end of frame it can also watch for the transceiver's heartbeat, a collision pulse that should follow transmission.

A 6-bit mode input controls the optional behaviour:

| Bit | Effect |
|-----|--------|
| 0 | Heartbeat check after each frame |
| 1 | Forced collision on every attempt, for self-test |
| 2 | Backoff countdown pauses while carrier sense is high |
| 3 | Receiver stays enabled while sending (local protect) |
| 4 | Selects the shorter late-collision threshold |
| 5 | Full duplex |

The per-frame result flags stay latched until the MAC opens the next frame. The MAC uses `backoff_done_o` as its cue to start the retransmission.

Top module: `txcol_supervisor`

## Requirements
- R1: While reset is held and just after it is released, every output is 0.
- R2: If mode bit 0 is 1 and mode bit 5 is 0, a clean frame end opens a heartbeat window of HB_WINDOW (40) transmit clock enables. In that window `busy_o` stays 1. If `col_i` is seen inside the window, the window closes without a flag. If the window expires with no collision, `hb_missing_o` is set and `busy_o` drops on the edge that counts the 40th enable.
- R3: If mode bit 0 is 0, `busy_o` drops on the frame-end edge and `hb_missing_o` is never set.
- R4: A collision is late when the byte count since the attempt started is at least 64 (mode bit 4 = 0) or at least 56 (mode bit 4 = 1). A late collision sets `late_col_o`, ends the frame at once (`busy_o` goes to 0) and leaves `attempts_o` unchanged.
- R5: An early collision does three things: it increments `attempts_o`, it raises `backoff_busy_o`, and it draws a slot count from 0 to 2^min(n,10)−1, where n is the new attempt count. Each slot lasts SLOT_TICKS bit ticks. `backoff_busy_o` stays high for slots×SLOT_TICKS+1 cycles. `backoff_done_o` is high in its last cycle, and after that the block is back in the sending state.
- R6: A collision on the attempt where `attempts_o` already reads 15 sets `retry_exc_o` and ends the frame. `attempts_o` stays at 15.
- R7: With mode bit 1 set, a collision occurs on every attempt without `col_i`. Every frame therefore ends with `retry_exc_o` = 1 and `attempts_o` = 15.
- R8: With mode bit 2 set, the backoff countdown holds while `crs_i` is 1 and continues once it falls.
- R9: With mode bit 2 clear, the backoff completes within its bound even while `crs_i` stays at 1.
- R10: `rx_block_o` is 1 exactly while a frame is being sent with mode bit 3 = 0. With mode bit 3 = 1 it stays 0.
- R11: With mode bit 5 set, collisions are ignored, no backoff starts, and no heartbeat window opens.
- R12: `hb_missing_o`, `late_col_o`, `retry_exc_o` and `attempts_o` hold their values until a `frame_start_i` accepted in the idle state clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 6 | Mode bits, see table above |
| frame_start_i | input | 1 | Opens a new frame (accepted when idle) |
| frame_end_i | input | 1 | Last bit of the current attempt sent |
| txclk_en_i | input | 1 | Transmit serial clock enable, paces the heartbeat window |
| bit_tick_i | input | 1 | One bit time, paces backoff slots |
| byte_tick_i | input | 1 | One byte sent in the current attempt |
| crs_i | input | 1 | Carrier sense |
| col_i | input | 1 | Collision from the transceiver |
| busy_o | output | 1 | A frame is open (sending, heartbeat wait or backoff) |
| rx_block_o | output | 1 | Receiver must be blocked |
| backoff_busy_o | output | 1 | Backoff wait in progress |
| backoff_done_o | output | 1 | Last backoff cycle; retransmission follows |
| attempts_o | output | 4 | Retransmissions of the current frame |
| hb_missing_o | output | 1 | Heartbeat not heard after the frame |
| late_col_o | output | 1 | Frame ended by a late collision |
| retry_exc_o | output | 1 | Frame ended after exhausting retries |

## Verification
The hardest state to reach from the ports is a frozen backoff. A freeze needs a non-zero random slot draw while carrier sense is high, and the first attempt draws zero half of the time. The stimulus solves this by holding carrier sense high and colliding again and again on the same frame. Each new attempt widens the draw range, and the bench stops at the first backoff that is still running after a few cycles. The retry limit needs sixteen consecutive collisions. It is reached once by driving `col_i` and once by forced-collision mode, and each backoff is checked against its per-attempt bound.

// File: rtl/txcol_pkg.sv
package txcol_pkg;

  // mode_i bit positions
  localparam int M_HB      = 0;
  localparam int M_FORCE   = 1;
  localparam int M_STOPBO  = 2;
  localparam int M_LOCALP  = 3;
  localparam int M_SHORTW  = 4;
  localparam int M_FDX     = 5;
  localparam int MODE_W    = 6;

  // width of the pseudo-random source and of the slot counter
  localparam int LFSR_W    = 16;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEND    = 2'd1,
    ST_HBWAIT  = 2'd2,
    ST_BACKOFF = 2'd3
  } sup_state_e;

  // byte offset from which a collision counts as late
  function automatic int late_limit(input logic short_win, input int long_b, input int short_b);
    return short_win ? short_b : long_b;
  endfunction

  // largest slot count for a given attempt number, exponent capped
  function automatic logic [LFSR_W-1:0] slot_mask(input int attempt, input int cap);
    int e;
    e = (attempt < cap) ? attempt : cap;
    return LFSR_W'((32'd1 << e) - 32'd1);
  endfunction

  // maximal-length 16-bit Fibonacci step
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

endpackage

// File: rtl/txcol_heartbeat.sv
module txcol_heartbeat #(
  parameter int HB_WINDOW = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic txclk_en_i,
  input  logic col_i,
  output logic miss_o,
  output logic heard_o
);
  localparam int CNT_W = (HB_WINDOW > 1) ? $clog2(HB_WINDOW) : 1;

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = (cnt_q == CNT_W'(HB_WINDOW - 1));
  assign heard_o   = active_q && col_i;
  assign miss_o    = active_q && !col_i && txclk_en_i && last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (arm_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (heard_o || miss_o) begin
        active_q <= 1'b0;
      end else if (txclk_en_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txcol_backoff.sv
module txcol_backoff
  import txcol_pkg::*;
#(
  parameter int              SLOT_TICKS  = 512,
  parameter int              BACKOFF_CAP = 10,
  parameter int              ATT_W       = 4,
  parameter logic [15:0]     SEED        = 16'hB5A3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ATT_W-1:0]  attempt_i,
  input  logic              bit_tick_i,
  input  logic              freeze_i,
  output logic              done_o,
  output logic [LFSR_W-1:0] slots_o
);
  localparam int TICK_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] slots_q;
  logic [TICK_W-1:0] tick_q;
  logic              busy_q;
  logic              advance;
  logic              slot_end;

  assign done_o   = busy_q && (slots_q == '0);
  assign advance  = busy_q && !done_o && bit_tick_i && !freeze_i;
  assign slot_end = (tick_q == TICK_W'(SLOT_TICKS - 1));
  assign slots_o  = slots_q;

  // free-running random source
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_step(lfsr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      slots_q <= '0;
      tick_q  <= '0;
    end else if (load_i) begin
      busy_q  <= 1'b1;
      slots_q <= lfsr_q & slot_mask(int'(attempt_i), BACKOFF_CAP);
      tick_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (advance) begin
      if (slot_end) begin
        tick_q  <= '0;
        slots_q <= slots_q - 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/txcol_supervisor.sv
module txcol_supervisor
  import txcol_pkg::*;
#(
  parameter int          SLOT_TICKS  = 512,
  parameter int          HB_WINDOW   = 40,
  parameter int          RETRY_LIMIT = 15,
  parameter int          BACKOFF_CAP = 10,
  parameter int          LATE_LONG   = 64,
  parameter int          LATE_SHORT  = 56,
  parameter logic [15:0] LFSR_SEED   = 16'hB5A3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [5:0]                         mode_i,
  input  logic                               frame_start_i,
  input  logic                               frame_end_i,
  input  logic                               txclk_en_i,
  input  logic                               bit_tick_i,
  input  logic                               byte_tick_i,
  input  logic                               crs_i,
  input  logic                               col_i,
  output logic                               busy_o,
  output logic                               rx_block_o,
  output logic                               backoff_busy_o,
  output logic                               backoff_done_o,
  output logic [$clog2(RETRY_LIMIT+1)-1:0]   attempts_o,
  output logic                               hb_missing_o,
  output logic                               late_col_o,
  output logic                               retry_exc_o
);
  localparam int ATT_W  = $clog2(RETRY_LIMIT + 1);
  localparam int BYTE_W = $clog2(LATE_LONG + 1);

  sup_state_e        state_q;
  logic [ATT_W-1:0]  attempts_q;
  logic [BYTE_W-1:0] byte_cnt;
  logic [BYTE_W-1:0] late_thr;
  logic [LFSR_W-1:0] bo_slots;
  logic              hb_q, late_q, exc_q;

  // named internal events
  logic in_send, fdx, col_seen, col_late, col_last, bo_load, hb_arm;
  logic hb_miss, hb_heard, bo_done, bo_freeze;

  assign fdx       = mode_i[M_FDX];
  assign in_send   = (state_q == ST_SEND);
  assign late_thr  = BYTE_W'(late_limit(mode_i[M_SHORTW], LATE_LONG, LATE_SHORT));
  assign col_seen  = in_send && !fdx && (col_i || mode_i[M_FORCE]);
  assign col_late  = col_seen && (byte_cnt >= late_thr);
  assign col_last  = col_seen && !col_late && (attempts_q == ATT_W'(RETRY_LIMIT));
  assign bo_load   = col_seen && !col_late && !col_last;
  assign hb_arm    = in_send && !col_seen && frame_end_i && mode_i[M_HB] && !fdx;
  assign bo_freeze = mode_i[M_STOPBO] && crs_i;

  txcol_heartbeat #(.HB_WINDOW(HB_WINDOW)) u_hb (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (hb_arm),
    .txclk_en_i (txclk_en_i),
    .col_i      (col_i),
    .miss_o     (hb_miss),
    .heard_o    (hb_heard)
  );

  txcol_backoff #(
    .SLOT_TICKS  (SLOT_TICKS),
    .BACKOFF_CAP (BACKOFF_CAP),
    .ATT_W       (ATT_W),
    .SEED        (LFSR_SEED)
  ) u_bo (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (bo_load),
    .attempt_i  (attempts_q + 1'b1),
    .bit_tick_i (bit_tick_i),
    .freeze_i   (bo_freeze),
    .done_o     (bo_done),
    .slots_o    (bo_slots)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      attempts_q <= '0;
      byte_cnt   <= '0;
      hb_q       <= 1'b0;
      late_q     <= 1'b0;
      exc_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (frame_start_i) begin
            state_q    <= ST_SEND;
            attempts_q <= '0;
            byte_cnt   <= '0;
            hb_q       <= 1'b0;
            late_q     <= 1'b0;
            exc_q      <= 1'b0;
          end
        end
        ST_SEND: begin
          if (byte_tick_i && (byte_cnt != '1)) byte_cnt <= byte_cnt + 1'b1;
          if (col_late) begin
            late_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (col_last) begin
            exc_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (bo_load) begin
            attempts_q <= attempts_q + 1'b1;
            state_q    <= ST_BACKOFF;
          end else if (frame_end_i) begin
            state_q <= hb_arm ? ST_HBWAIT : ST_IDLE;
          end
        end
        ST_HBWAIT: begin
          if (hb_miss) begin
            hb_q    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (hb_heard) begin
            state_q <= ST_IDLE;
          end
        end
        ST_BACKOFF: begin
          if (bo_done) begin
            byte_cnt <= '0;
            state_q  <= ST_SEND;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o         = (state_q != ST_IDLE);
  assign rx_block_o     = in_send && !mode_i[M_LOCALP];
  assign backoff_busy_o = (state_q == ST_BACKOFF);
  assign backoff_done_o = bo_done;
  assign attempts_o     = attempts_q;
  assign hb_missing_o   = hb_q;
  assign late_col_o     = late_q;
  assign retry_exc_o    = exc_q;
endmodule

// File: rtl/txcol_supervisor_chk.sv
module txcol_supervisor_chk
  import txcol_pkg::*;
#(
  parameter int RETRY_LIMIT = 15,
  parameter int ATT_W       = 4,
  parameter int BYTE_W      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        mode_i,
  input logic              frame_start_i,
  input logic              crs_i,
  input logic              busy_o,
  input logic              backoff_busy_o,
  input logic              backoff_done_o,
  input logic [ATT_W-1:0]  attempts_o,
  input logic              hb_missing_o,
  input logic              late_col_o,
  input logic              retry_exc_o,
  input logic [LFSR_W-1:0] bo_slots,
  input logic [BYTE_W-1:0] byte_cnt,
  input logic [BYTE_W-1:0] late_thr
);
  // R11
  fdx_no_backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backoff_busy_o) |-> !$past(mode_i[M_FDX]));

  // R8
  frozen_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (backoff_busy_o && $past(backoff_busy_o) && $past(mode_i[M_STOPBO] && crs_i))
      |-> (bo_slots == $past(bo_slots)));

  // R12
  late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(late_col_o) && !$past(frame_start_i)) |-> late_col_o);

  // R12
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(retry_exc_o) && !$past(frame_start_i)) |-> retry_exc_o);

  // R6
  exc_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retry_exc_o) |-> (attempts_o == ATT_W'(RETRY_LIMIT)));

  // R3
  hb_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_missing_o) |-> $past(mode_i[M_HB]));

  // R4
  late_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_col_o) |-> ($past(byte_cnt) >= $past(late_thr)));

  // R5
  resend_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_done_o |=> (busy_o && !backoff_busy_o));
endmodule

bind txcol_supervisor txcol_supervisor_chk #(
  .RETRY_LIMIT (RETRY_LIMIT),
  .ATT_W       (ATT_W),
  .BYTE_W      (BYTE_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_i         (mode_i),
  .frame_start_i  (frame_start_i),
  .crs_i          (crs_i),
  .busy_o         (busy_o),
  .backoff_busy_o (backoff_busy_o),
  .backoff_done_o (backoff_done_o),
  .attempts_o     (attempts_o),
  .hb_missing_o   (hb_missing_o),
  .late_col_o     (late_col_o),
  .retry_exc_o    (retry_exc_o),
  .bo_slots       (bo_slots),
  .byte_cnt       (byte_cnt),
  .late_thr       (late_thr)
);

// File: tb/txcol_supervisor_bench.sv
module txcol_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ST         = 2;
  localparam int WD_CYCLES  = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] mode = '0;
  logic       frame_start = 0, frame_end = 0, txclk_en = 1, bit_tick = 1;
  logic       byte_tick = 0, crs = 0, col = 0;
  logic       busy, rx_block, bo_busy, bo_done, hb_miss, late_col, retry_exc;
  logic [3:0] attempts;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txcol_supervisor #(.SLOT_TICKS(ST)) u_txcol_supervisor (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .frame_start_i(frame_start), .frame_end_i(frame_end),
    .txclk_en_i(txclk_en), .bit_tick_i(bit_tick), .byte_tick_i(byte_tick),
    .crs_i(crs), .col_i(col),
    .busy_o(busy), .rx_block_o(rx_block), .backoff_busy_o(bo_busy),
    .backoff_done_o(bo_done), .attempts_o(attempts),
    .hb_missing_o(hb_miss), .late_col_o(late_col), .retry_exc_o(retry_exc)
  );

  function automatic int max_slots(input int k);
    int e;
    e = (k < 10) ? k : 10;
    return (1 << e) - 1;
  endfunction

  // 0 = no effect, 1 = early, 2 = late
  function automatic int classify(input int nbytes, input bit short_w, input bit fdx, input bit hit);
    int thr;
    thr = short_w ? 56 : 64;
    if (!hit || fdx) return 0;
    return (nbytes >= thr) ? 2 : 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_frame();
    frame_start = 1; cyc(); frame_start = 0;
  endtask

  task automatic end_frame();
    frame_end = 1; cyc(); frame_end = 0;
  endtask

  task automatic send_bytes(input int n);
    if (n > 0) begin
      byte_tick = 1; cyc(n); byte_tick = 0;
    end
  endtask

  task automatic collide();
    col = 1; cyc(); col = 0;
  endtask

  // R5: measure the backoff just entered against its bound for attempt k
  task automatic run_backoff(input string req, input int k);
    int  n;
    bit  saw;
    n = 0; saw = 0;
    while (bo_busy && n < 5000) begin
      if (bo_done) saw = 1;
      n++;
      cyc();
    end
    chk({req, " backoff length within bound"}, int'(n >= 1 && n <= max_slots(k) * ST + 1), 1);
    chk({req, " done pulse seen"}, int'(saw), 1);
    chk({req, " resend after backoff"}, int'(busy), 1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit frozen;
    bit seen;
    int waited;
    void'($urandom(32'd20240611));

    // R1 reset state
    cyc(3);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 flags in reset", int'({hb_miss, late_col, retry_exc, bo_busy, bo_done, rx_block}), 0);
    rst_n = 1; cyc();
    chk("R1 outputs after reset", int'({busy, hb_miss, late_col, retry_exc, attempts}), 0);

    // R10 local protect clear / set
    mode = 6'b000000; start_frame();
    chk("R10 rx blocked while sending", int'(rx_block), 1);
    end_frame();
    chk("R10 rx released after frame", int'(rx_block), 0);
    // R3 no heartbeat wait
    chk("R3 idle right after frame end", int'(busy), 0);
    cyc(60);
    chk("R3 heartbeat flag never set", int'(hb_miss), 0);
    mode = 6'b001000; start_frame();
    chk("R10 rx open with local protect", int'(rx_block), 0);
    end_frame();

    // R2 heartbeat window expires
    mode = 6'b000001; start_frame(); end_frame();
    cyc(39);
    chk("R2 window still open at 39", int'({busy, hb_miss}), 2);
    cyc();
    chk("R2 missing flag at 40", int'({busy, hb_miss}), 1);
    // R12 held
    cyc(20);
    chk("R12 heartbeat flag held", int'(hb_miss), 1);
    // R2 heartbeat heard
    start_frame();
    chk("R12 flag cleared by frame start", int'(hb_miss), 0);
    end_frame(); cyc(10); collide();
    chk("R2 heard closes window", int'({busy, hb_miss}), 0);
    cyc(50);
    chk("R2 no flag when heard", int'(hb_miss), 0);
    // R2 window counts enables only
    start_frame(); end_frame();
    for (int i = 0; i < 60; i++) begin txclk_en = i[0]; cyc(); end
    chk("R2 gated enables stretch window", int'({busy, hb_miss}), 2);
    waited = 0;
    while (busy && waited < 100) begin txclk_en = ~txclk_en; waited++; cyc(); end
    txclk_en = 1;
    chk("R2 missing flag after gated window", int'(hb_miss), 1);

    // R4 thresholds
    mode = 6'b000000; start_frame(); send_bytes(63); collide();
    chk("R4 byte 63 is early", int'({late_col, bo_busy}), 1);
    run_backoff("R5 attempt 1", 1); end_frame();
    start_frame(); send_bytes(64); collide();
    chk("R4 byte 64 is late", int'({late_col, busy, attempts}), 32'h20);
    mode = 6'b010000; start_frame(); send_bytes(55); collide();
    chk("R4 short window byte 55 early", int'({late_col, bo_busy}), 1);
    run_backoff("R5 short window", 1); end_frame();
    start_frame(); send_bytes(56); collide();
    chk("R4 short window byte 56 late", int'({late_col, busy}), 2);

    // R6 retry limit through col_i, R5 per attempt
    mode = 6'b000000; start_frame();
    for (int k = 1; k <= 15; k++) begin
      collide();
      chk("R5 attempts increment", int'(attempts), k);
      run_backoff("R5 growing window", k);
    end
    collide();
    chk("R6 retry limit flag", int'({retry_exc, busy}), 2);
    chk("R6 attempts stay at limit", int'(attempts), 15);

    // R7 forced collision
    mode = 6'b000010; start_frame();
    waited = 0;
    while (busy && waited < 100000) begin waited++; cyc(); end
    chk("R7 forced run ends in retry limit", int'({retry_exc, late_col}), 2);
    chk("R7 forced attempts", int'(attempts), 15);
    mode = 6'b000000; cyc(30);
    chk("R12 retry flag held", int'(retry_exc), 1);
    start_frame();
    chk("R12 cleared by next frame", int'({retry_exc, attempts}), 0);
    end_frame();

    // R8 freeze while carrier sense
    mode = 6'b000100; start_frame(); crs = 1; frozen = 0;
    for (int t = 0; t < 12 && !frozen; t++) begin
      collide(); cyc(4);
      if (bo_busy) frozen = 1;
    end
    chk("R8 nonzero draw reached", int'(frozen), 1);
    seen = 0;
    for (int i = 0; i < 300; i++) begin if (bo_done) seen = 1; cyc(); end
    chk("R8 backoff held by carrier", int'({bo_busy, seen}), 2);
    crs = 0;
    waited = 0;
    while (bo_busy && waited < 5000) begin waited++; cyc(); end
    chk("R8 resumes after carrier drops", int'(waited <= max_slots(attempts) * ST + 1), 1);
    end_frame();

    // R9 carrier ignored without stop bit
    mode = 6'b000000; start_frame(); crs = 1;
    for (int k = 1; k <= 4; k++) begin
      collide(); run_backoff("R9 carrier ignored", k);
    end
    crs = 0; end_frame();

    // R11 full duplex
    mode = 6'b101001; start_frame(); collide();
    chk("R11 collision ignored", int'({busy, bo_busy, attempts}), 32'h20);
    end_frame();
    chk("R11 no heartbeat wait", int'({busy, hb_miss}), 0);

    // random frames
    for (int it = 0; it < 40; it++) begin
      bit sw, fd, lp, hit;
      int nb, exp;
      sw  = 1'($urandom_range(1));
      fd  = ($urandom_range(3) == 0);
      lp  = fd ? 1'b1 : 1'($urandom_range(1));
      hit = 1'($urandom_range(1));
      nb  = $urandom_range(90);
      mode = {fd, sw, lp, 3'b000};
      exp = classify(nb, sw, fd, hit);
      start_frame();
      chk("R10 random rx block", int'(rx_block), int'(!lp));
      send_bytes(nb);
      if (hit) collide();
      if (exp == 2) begin
        chk("R4 random late", int'({late_col, busy}), 2);
      end else if (exp == 1) begin
        chk("R4 random early", int'({late_col, bo_busy, attempts}), 32'h11);
        run_backoff("R5 random", 1);
        end_frame();
        chk("R5 random frame closes", int'({busy, late_col}), 0);
      end else begin
        chk("R11 random no effect", int'({busy, bo_busy, late_col}), 4);
        end_frame();
        chk("R11 random frame closes", int'(busy), 0);
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule